// File: doc/BRIEF.md
# Branch history rolling buffer

This block keeps a short trail of taken branches for performance-monitoring software. Each taken branch arrives as one event that carries the branch's own instruction address, its destination address, a five-bit kind vector and two privilege bits. The block decides whether the event should be kept. That decision depends on a monitor enable, a two-bit filter mode, a pair of freeze controls, and an extra suppression rule that applies only in newer-ISA mode. A kept event is written into a 32-entry ring of 64-bit words.

When a branch takes its destination from a register, the block writes a second word right after the first. That word holds the destination address with bit 1 set as a tag. The extra write costs one cycle, and `ev_ready` is low during that cycle. A registered read port returns the stored words ordered newest first. A synchronous clear empties the ring.

Top module: `branch_trace_ring`

## Requirements
- R1: After reset the write pointer is zero, every entry reads as zero and `ev_ready` is high.
- R2: While `mon_en` is low, no event is stored and the ring contents are unchanged.
- R3: Kind bits are: bit0 call, bit1 indirect, bit2 conditional, bit3 other, bit4 register-target. Filter mode 0 selects all five bits, mode 1 selects call, mode 2 selects indirect and mode 3 selects conditional. An event is stored only if its kind vector shares at least one bit with the selected set.
- R4: A stored event writes its instruction address at the write pointer. The pointer then advances by one and wraps modulo 32.
- R5: A stored event with kind bit4 set writes a second entry in the next clock cycle. That entry holds the destination address with bit 1 forced to 1, and the pointer advances again. `ev_ready` is low for exactly that one cycle.
- R6: When `isa_new` is high, nothing is stored if `rec_off` is high or `ev_user` is low.
- R7: Freeze rules, checked in this order:
  - When `frz_sel` and `frz_user` are both high, an event with `ev_hyp` and `ev_user` both high is dropped.
  - When `frz_sel` is high and `frz_user` is low, an event with `ev_hyp` low and `ev_user` high is dropped.
  - When `frz_sel` is low, `frz_user` high together with `ev_user` high drops the event.
- R8: `rd_data` presents, one clock after `rd_idx` is sampled, the entry at (pointer − 1 − `rd_idx`) mod 32. Index 0 is therefore the newest entry.
- R9: `clr` zeroes every entry and the pointer in one cycle. An event offered in the same cycle is dropped.
- R10: Control inputs take effect combinationally, so a new setting applies to the very next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Taken-branch event present |
| ev_ready | output | 1 | Block can accept an event this cycle |
| ev_inst_addr | input | 64 | Address of the branch instruction |
| ev_tgt_addr | input | 64 | Branch destination address |
| ev_kind | input | 5 | Kind vector (bit0 call, bit1 indirect, bit2 conditional, bit3 other, bit4 register-target) |
| ev_hyp | input | 1 | Event raised in hypervisor state |
| ev_user | input | 1 | Event raised in problem (user) state |
| mon_en | input | 1 | Monitor enable |
| filt_mode | input | 2 | Filter mode selector |
| frz_sel | input | 1 | Freeze-control select |
| frz_user | input | 1 | Freeze-problem-state control |
| rec_off | input | 1 | Recording disable (newer-ISA mode only) |
| isa_new | input | 1 | Newer-ISA mode |
| clr | input | 1 | Synchronous buffer clear |
| rd_idx | input | 5 | Read index, 0 = newest |
| rd_data | output | 64 | Registered read data |

## Verification
The assertions assume that an event counts only when `ev_valid` and `ev_ready` are both high. They also assume that `clr` is a pulse sampled on the clock like every other input. The stimulus holds each event for one cycle and, after a register-target event, waits out the cycle in which `ev_ready` is low before offering the next one. Control inputs and read indices change only on the falling edge, between events. The single case that deliberately offers an event together with `clr` is the one that checks clear priority.

// File: rtl/bhr_pkg.sv
// Shared constants and types for the branch history ring.
// Assumes a five-bit kind vector whose bit positions are fixed by the event source.
package bhr_pkg;
    localparam int KIND_W   = 5;
    localparam int KB_CALL  = 0;
    localparam int KB_IND   = 1;
    localparam int KB_COND  = 2;
    localparam int KB_OTHER = 3;
    localparam int KB_REGT  = 4;

    typedef enum logic [1:0] {
        FM_ALL  = 2'd0,
        FM_CALL = 2'd1,
        FM_IND  = 2'd2,
        FM_COND = 2'd3
    } filt_mode_e;
endpackage

// File: rtl/bhr_gate.sv
// Decides whether a branch event is kept. This is purely combinational.
// Assumes the control inputs are stable for the cycle in which the event is offered.
module bhr_gate
    import bhr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic [1:0]        filt_mode,
    input  logic              frz_sel,
    input  logic              frz_user,
    input  logic              rec_off,
    input  logic              isa_new,
    input  logic [KIND_W-1:0] kind,
    input  logic              hyp,
    input  logic              user,
    output logic              rec_ok
);
    logic [KIND_W-1:0] sel_set;
    logic              frozen;
    logic              isa_block;

    // Build the selected kind set from the enable and the filter mode.
    always_comb begin
        sel_set = '0;
        if (mon_en) begin
            case (filt_mode_e'(filt_mode))
                FM_ALL:  sel_set = '1;
                FM_CALL: sel_set[KB_CALL] = 1'b1;
                FM_IND:  sel_set[KB_IND]  = 1'b1;
                FM_COND: sel_set[KB_COND] = 1'b1;
                default: sel_set = '0;
            endcase
        end
    end

    // Apply the privilege-state freeze rules.
    always_comb begin
        if (frz_sel) begin
            frozen = frz_user ? (hyp && user) : (!hyp && user);
        end else begin
            frozen = frz_user && user;
        end
    end

    // Apply the extra suppression of newer-ISA mode.
    always_comb isa_block = isa_new && (rec_off || !user);

    // Combine the type match with both suppression paths.
    always_comb rec_ok = (|(kind & sel_set)) && !frozen && !isa_block;

    a_r2_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |-> !rec_ok);
    a_r6_isa_supervisor_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_new && !user) |-> !rec_ok);
endmodule

// File: rtl/bhr_wrseq.sv
// Write sequencer: owns the write pointer and the second, tagged write of a
// register-target branch.
// Assumes that take is never raised while pending is high.
module bhr_wrseq #(
    parameter int DW = 64,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic          regt,
    input  logic [DW-1:0] inst_addr,
    input  logic [DW-1:0] tgt_addr,
    output logic          wr_en,
    output logic          wr_tag,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] ptr,
    output logic          pending
);
    logic [DW-1:0] tgt_q;

    // Select this cycle's write: the instruction address first, then the tagged destination.
    always_comb begin
        wr_en   = (take || pending) && !clr;
        wr_tag  = pending;
        wr_addr = ptr;
        wr_data = pending ? (tgt_q | DW'(2)) : inst_addr;
    end

    // Advance the pointer on every write; clear returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (wr_en) begin
            ptr <= ptr + AW'(1);
        end
    end

    // Keep the destination address for the second write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pending <= 1'b0;
            tgt_q   <= '0;
        end else if (take && regt && !pending) begin
            pending <= 1'b1;
            tgt_q   <= tgt_addr;
        end else begin
            pending <= 1'b0;
        end
    end

    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (clr || ptr == AW'($past(ptr) + AW'(1))));
    a_r5_second_write: assert property (@(posedge clk) disable iff (!rst_n)
        (take && regt && !clr && !pending) |=> (pending || clr));
    a_r5_one_extra_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !pending);
    a_r9_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0 && !pending));
endmodule

// File: rtl/bhr_mem.sv
// Register-file storage for the ring, with one write port and one registered read port.
// Assumes the caller has already turned a newest-first index into a physical address.
module bhr_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          wr_tag,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Hold entry g; it is zeroed by reset or clear and loaded on an address match.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ent[g] <= '0;
            end else if (wr_en && wr_addr == AW'(g)) begin
                ent[g] <= wr_data;
            end
        end
    end

    // Register the selected entry onto the read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= ent[rd_addr];
        end
    end

    a_r5_tag_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tag) |-> wr_data[1]);
endmodule

// File: rtl/branch_trace_ring.sv
// Top level of the branch history ring. It connects the gate, the write sequencer
// and the storage, and it maps newest-first read indices onto physical slots.
// Assumes an event is counted only when ev_valid and ev_ready are both high.
module branch_trace_ring
    import bhr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [DW-1:0]     ev_inst_addr,
    input  logic [DW-1:0]     ev_tgt_addr,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic              ev_hyp,
    input  logic              ev_user,
    input  logic              mon_en,
    input  logic [1:0]        filt_mode,
    input  logic              frz_sel,
    input  logic              frz_user,
    input  logic              rec_off,
    input  logic              isa_new,
    input  logic              clr,
    input  logic [AW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data
);
    logic          rec_ok;
    logic          take;
    logic          pending;
    logic          wr_en;
    logic          wr_tag;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] ptr;
    logic [AW-1:0] rd_addr;

    bhr_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .filt_mode (filt_mode),
        .frz_sel   (frz_sel),
        .frz_user  (frz_user),
        .rec_off   (rec_off),
        .isa_new   (isa_new),
        .kind      (ev_kind),
        .hyp       (ev_hyp),
        .user      (ev_user),
        .rec_ok    (rec_ok)
    );

    // Accept new events only when no tagged write is still outstanding.
    always_comb ev_ready = !pending;

    // Qualify an accepted event; a clear in the same cycle drops it.
    always_comb take = ev_valid && ev_ready && !clr && rec_ok;

    // Convert the newest-first index into a physical slot.
    always_comb rd_addr = ptr - AW'(1) - rd_idx;

    bhr_wrseq #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .take      (take),
        .regt      (ev_kind[KB_REGT]),
        .inst_addr (ev_inst_addr),
        .tgt_addr  (ev_tgt_addr),
        .wr_en     (wr_en),
        .wr_tag    (wr_tag),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .pending   (pending)
    );

    bhr_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    a_r5_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ready |=> ev_ready);
    a_r2_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !pending) |=> $stable(ptr) || $past(clr));
    a_r1_reset_ptr: assert property (@(posedge clk)
        $past(!rst_n) |-> (ptr == '0 && ev_ready));
endmodule

// File: tb/branch_trace_ring_tb_top.sv
// Directed bench: each scenario task drives its own stimulus and checks the result
// against a reference model of the ring kept in the bench.
module branch_trace_ring_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [63:0] ev_inst_addr = '0;
    logic [63:0] ev_tgt_addr = '0;
    logic [4:0]  ev_kind = '0;
    logic        ev_hyp = 1'b0;
    logic        ev_user = 1'b1;
    logic        mon_en = 1'b0;
    logic [1:0]  filt_mode = 2'd0;
    logic        frz_sel = 1'b0;
    logic        frz_user = 1'b0;
    logic        rec_off = 1'b0;
    logic        isa_new = 1'b0;
    logic        clr = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mmem [32];
    int mptr = 0;

    always #10 clk = ~clk;

    branch_trace_ring dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_inst_addr(ev_inst_addr), .ev_tgt_addr(ev_tgt_addr), .ev_kind(ev_kind),
        .ev_hyp(ev_hyp), .ev_user(ev_user), .mon_en(mon_en), .filt_mode(filt_mode),
        .frz_sel(frz_sel), .frz_user(frz_user), .rec_off(rec_off), .isa_new(isa_new),
        .clr(clr), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected keep decision, taken from the requirement text.
    function automatic bit exp_rec(logic [4:0] k, logic h, logic u);
        logic [4:0] s;
        if (!mon_en) return 1'b0;
        case (filt_mode)
            2'd0: s = 5'b11111;
            2'd1: s = 5'b00001;
            2'd2: s = 5'b00010;
            default: s = 5'b00100;
        endcase
        if (isa_new && (rec_off || !u)) return 1'b0;
        if (frz_sel && frz_user && h && u) return 1'b0;
        if (frz_sel && !frz_user && !h && u) return 1'b0;
        if (!frz_sel && frz_user && u) return 1'b0;
        return (k & s) != 5'b0;
    endfunction

    task automatic model_put(logic [63:0] v);
        mmem[mptr] = v;
        mptr = (mptr + 1) % 32;
    endtask

    // Offer one event; the task starts and ends on a falling edge.
    task automatic send(string req, logic [63:0] ia, logic [63:0] ta, logic [4:0] k,
                        logic h, logic u);
        bit r;
        r = exp_rec(k, h, u);
        ev_valid = 1'b1; ev_inst_addr = ia; ev_tgt_addr = ta;
        ev_kind = k; ev_hyp = h; ev_user = u;
        @(negedge clk);
        ev_valid = 1'b0;
        if (r) begin
            model_put(ia);
            if (k[4]) begin
                check({req, " R5 ready low"}, 64'(ev_ready), 64'd0);
                @(negedge clk);
                model_put(ta | 64'd2);
            end
        end
        check({req, " ready high"}, 64'(ev_ready), 64'd1);
    endtask

    task automatic read_one(string req, int idx);
        rd_idx = 5'(idx);
        @(negedge clk);
        check(req, rd_data, mmem[(mptr - 1 - idx + 64) % 32]);
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 32; i++) read_one(req, i);
    endtask

    task automatic t_reset();
        check("R1 ready after reset", 64'(ev_ready), 64'd1);
        read_all("R1 zero entries");
    endtask

    task automatic t_basic();
        mon_en = 1'b1; filt_mode = 2'd0;
        send("R4", 64'h1000, 64'h2000, 5'b00001, 1'b0, 1'b1);
        send("R4", 64'h1104, 64'h2000, 5'b00100, 1'b0, 1'b1);
        send("R4", 64'h1208, 64'h2000, 5'b01000, 1'b1, 1'b0);
        send("R4", 64'h130c, 64'h2000, 5'b00010, 1'b0, 1'b0);
        read_all("R8 newest first after basic writes");
    endtask

    task automatic t_disabled();
        mon_en = 1'b0;
        send("R2", 64'hdead0000, 64'h0, 5'b11111, 1'b0, 1'b1);
        send("R2", 64'hdead0004, 64'h0, 5'b00001, 1'b0, 1'b1);
        read_all("R2 unchanged while disabled");
        mon_en = 1'b1;
    endtask

    task automatic t_filters();
        for (int m = 1; m < 4; m++) begin
            filt_mode = 2'(m);
            for (int b = 0; b < 4; b++)
                send("R3", 64'h5000 + 64'(m * 16 + b * 4), 64'h0, 5'(1 << b), 1'b0, 1'b1);
        end
        read_all("R3 filter modes");
        filt_mode = 2'd0;
    endtask

    task automatic t_regtgt();
        filt_mode = 2'd0;
        send("R5", 64'h7000, 64'h8000_0040, 5'b10010, 1'b0, 1'b1);
        read_one("R5 tagged target at index 0", 0);
        read_one("R5 branch address at index 1", 1);
        filt_mode = 2'd2;
        send("R5 filter", 64'h7100, 64'h9000, 5'b10010, 1'b0, 1'b1);
        read_one("R5 second pair", 0);
        filt_mode = 2'd0;
    endtask

    task automatic t_isa();
        isa_new = 1'b1;
        send("R6 supervisor", 64'ha000, 64'h0, 5'b01000, 1'b0, 1'b0);
        rec_off = 1'b1;
        send("R6 disable bit", 64'ha004, 64'h0, 5'b01000, 1'b0, 1'b1);
        rec_off = 1'b0;
        send("R6 allowed", 64'ha008, 64'h0, 5'b01000, 1'b0, 1'b1);
        read_all("R6 newer-ISA suppression");
        isa_new = 1'b0;
    endtask

    task automatic t_freeze();
        for (int c = 0; c < 16; c++) begin
            frz_sel = c[3]; frz_user = c[2];
            send("R7", 64'hb000 + 64'(c * 4), 64'h0, 5'b00100, c[1], c[0]);
        end
        read_all("R7 freeze rules");
        frz_sel = 1'b0; frz_user = 1'b0;
    endtask

    task automatic t_switch();
        filt_mode = 2'd1;
        send("R10", 64'hc000, 64'h0, 5'b00001, 1'b0, 1'b1);
        filt_mode = 2'd3;
        send("R10", 64'hc004, 64'h0, 5'b00001, 1'b0, 1'b1);
        send("R10", 64'hc008, 64'h0, 5'b00100, 1'b0, 1'b1);
        read_one("R10 new mode on next event", 0);
        read_one("R10 old mode event", 1);
        filt_mode = 2'd0;
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 40; i++)
            send("R4 wrap", 64'hd000 + 64'(i * 4), 64'h0, 5'b01000, 1'b0, 1'b1);
        send("R4 wrap pair", 64'hd800, 64'he000, 5'b10001, 1'b0, 1'b1);
        read_all("R4 wrap modulo 32");
    endtask

    task automatic t_clear();
        clr = 1'b1;
        ev_valid = 1'b1; ev_inst_addr = 64'hf000; ev_kind = 5'b01000; ev_user = 1'b1;
        @(negedge clk);
        clr = 1'b0; ev_valid = 1'b0;
        for (int i = 0; i < 32; i++) mmem[i] = '0;
        mptr = 0;
        check("R9 ready after clear", 64'(ev_ready), 64'd1);
        read_all("R9 cleared, event dropped");
        send("R9", 64'hf100, 64'h0, 5'b01000, 1'b0, 1'b1);
        read_one("R9 pointer restarted", 0);
        read_one("R9 rest still zero", 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_disabled();
        t_filters();
        t_regtgt();
        t_isa();
        t_freeze();
        t_switch();
        t_wrap();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule